// File: doc/BRIEF.md
# Masked Register Power-Sequence Engine

The engine walks a fixed table of power-sequence steps held in an internal ROM and turns each step into register-bus traffic. A step can read a register and report its masked value, update selected bits of a register by read-modify-write, read a register repeatedly until a masked compare matches, or wait a set number of microseconds or milliseconds. An end step stops the walk. A step runs only if the configured chip revision, fab and host interface all match that step's masks. Steps that do not match are passed over with no bus traffic.

A controller pulses `start` with the configuration inputs held steady. It then watches `done` for a normal finish or `error` for a poll that ran out of attempts. When `error` is raised, `err_index` holds the index of the failing step.

The register port is a valid/ready request channel. The engine raises `bus_valid` with address, direction and write data, and holds all of them steady until the responder asserts `bus_ready`. A transfer happens in a cycle where both are high, and read data is taken from `bus_rdata` in that same cycle. The responder may hold `bus_ready` low for any number of cycles to apply back-pressure. The masked-read result port (`rd_valid`/`rd_data`) is a one-cycle pulse with no back-pressure.

Top module: `pwrseq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_valid` and `rd_valid` are all low.
- R2: A step other than end executes only when (revision mask & `cfg_rev`), (fab mask & `cfg_fab`) and (interface mask & `cfg_intf`) are each nonzero. Otherwise it is skipped with no bus request. Revision bit 0 is the test chip and bits 1..7 are revisions A..G. Interface bit 0 is SDIO, bit 1 is USB and bit 2 is PCIe.
- R3: Every request carries `bus_addr` = {base[3:0], offset[15:0]}. The base values are 0 for MAC, 1 for USB, 2 for PCIe and 3 for SDIO.
- R4: A read step (command 0) issues one read. In the cycle after the transfer it pulses `rd_valid` for one cycle with `rd_data` = read data & bit mask. The step's value field has no effect.
- R5: A write step (command 1) reads the register, then writes (old & ~mask) | (value & mask) to the same address.
- R6: A poll step (command 2) reads repeatedly until (data & mask) == (value & mask), then moves to the next step.
- R7: If a poll reaches POLL_LIMIT reads (20000 by default) without a match, the engine stops. It raises `error`, sets `err_index` to the step index, and issues no further requests until the next `start`.
- R8: A delay step (command 3) takes its count from the offset field. Value bit 0 picks the unit: 0 waits count×CYC_PER_US cycles and 1 waits count×1000×CYC_PER_US cycles. A count of 0 ends the wait at once.
- R9: While `bus_valid` is high and `bus_ready` is low, the request fields stay stable. The sequence advances only on a completed transfer.
- R10: An end step (command 4) is honoured whatever its masks. It raises `done`, which stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the walk from step 0 when not busy |
| cfg_rev | input | 8 | Revision select, one-hot |
| cfg_fab | input | 4 | Fab select |
| cfg_intf | input | 4 | Host interface select |
| bus_valid | output | 1 | Register request pending |
| bus_ready | input | 1 | Responder accepts the request this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 20 | {base, offset} |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid when bus_ready is high |
| rd_valid | output | 1 | Masked read result pulse |
| rd_data | output | 8 | Masked read result |
| busy | output | 1 | Walk in progress |
| done | output | 1 | End step reached |
| error | output | 1 | Poll timed out |
| err_index | output | IDX_W | Index of the timed-out step |

## Verification
The assertions check several properties on every cycle. A stalled request must hold its fields steady. A result pulse must follow a completed read, and a write must follow a completed read. The poll attempt count stays in range, and the microsecond prescaler stays bounded. `done` and `error` hold until a new start, with `err_index` frozen. The bench scenarios show the rest. They check mask filtering under different configurations, the exact addresses and merged write values, the number of poll reads before a match or a timeout, and the total length of a combined microsecond, zero-millisecond and one-millisecond wait.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam logic [3:0] CMD_READ  = 4'd0;
  localparam logic [3:0] CMD_WRITE = 4'd1;
  localparam logic [3:0] CMD_POLL  = 4'd2;
  localparam logic [3:0] CMD_DELAY = 4'd3;
  localparam logic [3:0] CMD_END   = 4'd4;

  typedef struct packed {
    logic [15:0] offset;
    logic [7:0]  rev_m;
    logic [3:0]  fab_m;
    logic [3:0]  intf_m;
    logic [3:0]  base;
    logic [3:0]  cmd;
    logic [7:0]  bmask;
    logic [7:0]  val;
  } step_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_READ, ST_RMW_RD, ST_RMW_WR,
    ST_POLL, ST_WAIT, ST_DONE, ST_FAIL
  } seq_state_t;

  function automatic step_t table_step(input int unsigned i);
    step_t s;
    s = '{offset: 16'h0000, rev_m: 8'hFF, fab_m: 4'hF, intf_m: 4'hF,
          base: 4'h0, cmd: CMD_END, bmask: 8'h00, val: 8'h00};
    case (i)
      0: begin s.offset = 16'h0010; s.cmd = CMD_WRITE; s.bmask = 8'h0F; s.val = 8'h05; end
      1: begin s.offset = 16'h0020; s.base = 4'h1; s.cmd = CMD_READ; s.bmask = 8'hF0; s.val = 8'hAA; end
      2: begin s.offset = 16'h0030; s.base = 4'h2; s.cmd = CMD_WRITE; s.bmask = 8'h3C; s.val = 8'h33;
               s.rev_m = 8'h04; s.intf_m = 4'h4; end
      3: begin s.offset = 16'h0040; s.cmd = CMD_POLL; s.bmask = 8'h80; s.val = 8'h80; end
      4: begin s.offset = 16'd3; s.cmd = CMD_DELAY; s.val = 8'h00; end
      5: begin s.offset = 16'd0; s.cmd = CMD_DELAY; s.val = 8'h01; end
      6: begin s.offset = 16'd1; s.cmd = CMD_DELAY; s.val = 8'h01; end
      default: s.cmd = CMD_END;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwrseq_rom.sv
module pwrseq_rom
  import pwrseq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  localparam int DEPTH = 1 << IDX_W;

  step_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rom[g] = table_step(g);
  end

  assign step = rom[idx];
endmodule

// File: rtl/pwrseq_filter.sv
module pwrseq_filter
  import pwrseq_pkg::*;
(
  input  step_t      step,
  input  logic [7:0] cfg_rev,
  input  logic [3:0] cfg_fab,
  input  logic [3:0] cfg_intf,
  output logic       hit
);
  assign hit = (|(step.rev_m & cfg_rev)) &&
               (|(step.fab_m & cfg_fab)) &&
               (|(step.intf_m & cfg_intf));
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CYC_PER_US = 100,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             unit_ms,
  output logic             idle
);
  localparam int US_W  = CNT_W + 10;
  localparam int SUB_W = $clog2(CYC_PER_US + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYC_PER_US - 1);

  logic [US_W-1:0]  us_left;
  logic [SUB_W-1:0] sub;
  logic [US_W-1:0]  load_val;

  assign load_val = unit_ms ? US_W'(count) * US_W'(1000) : US_W'(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_left <= '0;
      sub     <= '0;
    end else if (load) begin
      us_left <= load_val;
      sub     <= '0;
    end else if (us_left != '0) begin
      if (sub == SUB_LAST) begin
        sub     <= '0;
        us_left <= us_left - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign idle = (us_left == '0);

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= SUB_LAST);  // R8
  AST_US_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && us_left != '0) |=> (us_left <= $past(us_left)));  // R8
endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
  import pwrseq_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int CYC_PER_US = 100,
  parameter int POLL_LIMIT = 20000,
  parameter int IDX_W      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cfg_rev,
  input  logic [3:0]       cfg_fab,
  input  logic [3:0]       cfg_intf,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic             bus_we,
  output logic [19:0]      bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [IDX_W-1:0] err_index
);
  localparam int TRY_W = $clog2(POLL_LIMIT + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_LIMIT - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [TRY_W-1:0] tries;
  logic [7:0]       wdata_q;
  step_t            step;
  logic             hit;
  logic             tmr_idle;
  logic             tmr_load;
  logic             xfer;
  logic             poll_match;

  pwrseq_rom #(.IDX_W(IDX_W)) rom_i (.idx(idx), .step(step));

  pwrseq_filter filt_i (
    .step(step), .cfg_rev(cfg_rev), .cfg_fab(cfg_fab), .cfg_intf(cfg_intf), .hit(hit)
  );

  assign tmr_load = (state == ST_FETCH) && hit && (step.cmd == CMD_DELAY);

  pwrseq_timer #(.CYC_PER_US(CYC_PER_US), .CNT_W(16)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .count(step.offset),
    .unit_ms(step.val[0]), .idle(tmr_idle)
  );

  assign xfer       = bus_valid && bus_ready;
  assign poll_match = ((bus_rdata ^ step.val) & step.bmask) == 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      tries     <= '0;
      wdata_q   <= '0;
      err_index <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            idx   <= '0;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          tries <= '0;
          if (step.cmd == CMD_END) begin
            state <= ST_DONE;
          end else if (!hit) begin
            idx <= idx + 1'b1;
          end else begin
            case (step.cmd)
              CMD_READ:  state <= ST_READ;
              CMD_WRITE: state <= ST_RMW_RD;
              CMD_POLL:  state <= ST_POLL;
              CMD_DELAY: state <= ST_WAIT;
              default:   idx   <= idx + 1'b1;
            endcase
          end
        end
        ST_READ: begin
          if (bus_ready) begin
            rd_valid <= 1'b1;
            rd_data  <= bus_rdata & step.bmask;
            idx      <= idx + 1'b1;
            state    <= ST_FETCH;
          end
        end
        ST_RMW_RD: begin
          if (bus_ready) begin
            wdata_q <= (bus_rdata & ~step.bmask) | (step.val & step.bmask);
            state   <= ST_RMW_WR;
          end
        end
        ST_RMW_WR: begin
          if (bus_ready) begin
            idx   <= idx + 1'b1;
            state <= ST_FETCH;
          end
        end
        ST_POLL: begin
          if (bus_ready) begin
            if (poll_match) begin
              idx   <= idx + 1'b1;
              state <= ST_FETCH;
            end else if (tries == TRY_LAST) begin
              err_index <= idx;
              state     <= ST_FAIL;
            end else begin
              tries <= tries + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tmr_idle) begin
            idx   <= idx + 1'b1;
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid = (state == ST_READ) || (state == ST_RMW_RD) ||
                     (state == ST_RMW_WR) || (state == ST_POLL);
  assign bus_we    = (state == ST_RMW_WR);
  assign bus_addr  = {step.base, step.offset};
  assign bus_wdata = (state == ST_RMW_WR) ? wdata_q : 8'h00;
  assign done      = (state == ST_DONE);
  assign error     = (state == ST_FAIL);
  assign busy      = !(state == ST_IDLE || state == ST_DONE || state == ST_FAIL);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));  // R9
  AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(xfer && !bus_we));  // R4
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(xfer && !bus_we));  // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(POLL_LIMIT));  // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> (error && $stable(err_index)));  // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);  // R10
endmodule

// File: tb/pwrseq_engine_tb.sv
`timescale 1ns/1ps
module pwrseq_engine_tb_top;
  localparam int ENTRIES    = 8;
  localparam int CYC        = 4;
  localparam int PLIM       = 16;
  localparam int IDX_W      = 3;
  localparam logic [19:0] A_WR   = 20'h00010;
  localparam logic [19:0] A_RD   = 20'h10020;
  localparam logic [19:0] A_OPT  = 20'h20030;
  localparam logic [19:0] A_POLL = 20'h00040;

  typedef struct {
    bit          we;
    logic [19:0] addr;
    logic [7:0]  data;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cfg_rev = 8'h02;
  logic [3:0] cfg_fab = 4'h1;
  logic [3:0] cfg_intf = 4'h2;
  logic bus_valid, bus_we, bus_ready = 1'b0;
  logic [19:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00;
  logic rd_valid;
  logic [7:0] rd_data;
  logic busy, done, error;
  logic [IDX_W-1:0] err_index;

  always #2.5 clk = ~clk;

  pwrseq_engine #(.ENTRIES(ENTRIES), .CYC_PER_US(CYC), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rev(cfg_rev), .cfg_fab(cfg_fab),
    .cfg_intf(cfg_intf), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .error(error),
    .err_index(err_index)
  );

  int checks = 0;
  int errors = 0;
  item_t exp_bus[$];
  logic [7:0] exp_rd[$];
  logic [7:0] regs[logic [19:0]];
  int cyc = 0;
  int last_hs = 0;
  int poll_cnt = 0;
  int hit_after = 0;
  bit slow = 1'b0;
  int wait_left = 0;
  int pace = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_rd(logic [19:0] a, string req);
    item_t it;
    it.we = 1'b0; it.addr = a; it.data = 8'h00; it.req = req;
    exp_bus.push_back(it);
  endtask

  task automatic push_wr(logic [19:0] a, logic [7:0] d, string req);
    item_t it;
    it.we = 1'b1; it.addr = a; it.data = d; it.req = req;
    exp_bus.push_back(it);
  endtask

  function automatic logic [7:0] model_rd(logic [19:0] a);
    return regs.exists(a) ? regs[a] : 8'h00;
  endfunction

  // Responder and scoreboard monitor, evaluated away from the active edge.
  always @(negedge clk) begin
    if (!rst_n || !bus_valid) begin
      bus_ready = 1'b0;
    end else if (wait_left > 0) begin
      bus_ready = 1'b0;
      wait_left--;
    end else begin
      item_t it;
      bus_ready = 1'b1;
      last_hs = cyc;
      if (exp_bus.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected request: actual addr 0x%0h we %0b expected none",
                 bus_addr, bus_we);
      end else begin
        it = exp_bus.pop_front();
        check(it.req, {12'h0, bus_addr}, {12'h0, it.addr}, "request address");
        check(it.req, {31'h0, bus_we}, {31'h0, it.we}, "request direction");
        if (it.we) check(it.req, {24'h0, bus_wdata}, {24'h0, it.data}, "write data");
      end
      if (bus_we) begin
        regs[bus_addr] = bus_wdata;
      end else if (bus_addr == A_POLL) begin
        bus_rdata = (poll_cnt >= hit_after) ? (model_rd(A_POLL) | 8'h80) : 8'h00;
        poll_cnt++;
      end else begin
        bus_rdata = model_rd(bus_addr);
      end
      if (slow) begin
        wait_left = pace % 3;
        pace++;
      end
    end
    if (rst_n && rd_valid) begin
      if (exp_rd.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected result: actual 0x%0h expected none", rd_data);
      end else begin
        check("R4", {24'h0, rd_data}, {24'h0, exp_rd.pop_front()}, "masked read result");
      end
    end
  end

  task automatic run_to_end();
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk); n++;
    end
    if (n >= 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual no finish expected done or error");
    end
  endtask

  initial begin
    int gap;
    regs[A_WR] = 8'hA3;
    regs[A_RD] = 8'h5C;
    regs[A_OPT] = 8'hC3;
    regs[A_POLL] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", {27'h0, busy, done, error, bus_valid, rd_valid}, 32'h0, "reset outputs");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // A: revision A, USB host; optional PCIe step skipped, poll hits on 4th read
    cfg_rev = 8'h02; cfg_fab = 4'h1; cfg_intf = 4'h2;
    hit_after = 3; poll_cnt = 0; slow = 1'b0;
    push_rd(A_WR, "R5"); push_wr(A_WR, 8'hA5, "R5");
    push_rd(A_RD, "R3"); exp_rd.push_back(8'h50);
    for (int i = 0; i < 4; i++) push_rd(A_POLL, "R6");
    run_to_end();
    gap = cyc - last_hs;
    check("R10", {30'h0, done, error}, 32'h2, "done without error");
    check("R6", exp_bus.size(), 0, "pending requests after poll match");
    check("R2", {24'h0, model_rd(A_OPT)}, 32'hC3, "filtered step left register");
    check("R8", (gap >= 1003*CYC && gap <= 1003*CYC + 16) ? 1 : 0, 1, "delay length window");
    repeat (10) @(negedge clk);
    check("R10", {31'h0, done}, 1, "done held while idle");

    // B: revision B, PCIe host; optional step runs, slow responder, immediate poll match
    cfg_rev = 8'h04; cfg_intf = 4'h4;
    hit_after = 0; poll_cnt = 0; slow = 1'b1;
    push_rd(A_WR, "R5"); push_wr(A_WR, 8'hA5, "R5");
    push_rd(A_RD, "R9"); exp_rd.push_back(8'h50);
    push_rd(A_OPT, "R3"); push_wr(A_OPT, 8'hF3, "R3");
    push_rd(A_POLL, "R6");
    run_to_end();
    check("R10", {30'h0, done, error}, 32'h2, "done after slow run");
    check("R9", exp_bus.size() + exp_rd.size(), 0, "all requests seen under back-pressure");
    check("R5", {24'h0, model_rd(A_OPT)}, 32'hF3, "merged write value");

    // E: fab selects nothing; only the end step acts
    cfg_fab = 4'h0; slow = 1'b0;
    run_to_end();
    check("R2", {30'h0, done, error}, 32'h2, "all steps filtered");
    check("R2", exp_bus.size(), 0, "no requests when filtered");

    // C: poll never matches
    cfg_rev = 8'h02; cfg_fab = 4'h1; cfg_intf = 4'h2;
    hit_after = 1000; poll_cnt = 0;
    push_rd(A_WR, "R5"); push_wr(A_WR, 8'hA5, "R5");
    push_rd(A_RD, "R3"); exp_rd.push_back(8'h50);
    for (int i = 0; i < PLIM; i++) push_rd(A_POLL, "R7");
    run_to_end();
    check("R7", {30'h0, done, error}, 32'h1, "timeout flags");
    check("R7", {29'h0, err_index}, 32'd3, "failing step index");
    check("R7", poll_cnt, PLIM, "poll attempts");
    repeat (20) @(negedge clk);
    check("R7", {30'h0, bus_valid, error}, 32'h1, "quiet after timeout");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule